// File: doc/BRIEF.md
# Run-Length Background Image Decoder

This block turns a compressed background image, held as a byte stream in a synchronous ROM, into a stream of 7-bit luma pixels for a video pipeline. Each byte is either a single pixel or the head of a run. A run head is followed by one to three length bytes that together give the repeat count. The decoder reads the ROM one byte at a time and sends pixels out on a valid/ready handshake. A small fixed palette turns each luma value into a 24-bit colour that travels with the pixel.

The video side pulses a frame-start input at the top of each frame. The pulse sends the read pointer back to the image base and drops any pixel that has not yet been taken. While the downstream ready is low, the decoder holds its output pixel unchanged and issues no ROM reads. A stall therefore never loses or reorders data.

Top module: `rle_pixel_decoder`

## Requirements
- R1: During reset `pix_valid` and `rom_rd` are low and `rom_addr` equals the image base address (parameter `IMG_BASE`).
- R2: A byte with bit 0 equal to 0 produces exactly one pixel whose luma is bits 7:1 of that byte. Decoding then continues with the next byte.
- R3: A byte with bit 0 equal to 1 is a run head. Bits 7:1 give the luma to repeat, and a count of N given by the length bytes produces exactly N pixels of that luma.
- R4: Each length byte carries 7 count bits in bits 7:1, and its bit 0 set to 1 means another length byte follows. The first length byte gives count bits 6:0, the second gives bits 13:7, and the third gives bits 20:14.
- R5: A run whose count is 0 produces no pixel, and the byte after its last length byte is decoded as a new head.
- R6: Bit 0 of the third length byte is ignored. The byte after it is always decoded as a new head.
- R7: While `pix_ready` is low, `rom_rd` stays low, and a pixel already presented keeps `pix_valid` high with `pix_luma` unchanged.
- R8: In the cycle after `frame_start` is high, `pix_valid` is low and `rom_addr` equals `IMG_BASE`. Decoding then restarts from the first byte of the image.
- R9: ROM reads step through consecutive addresses. The read data is used in the cycle after each read.
- R10: `pix_rgb` holds red in bits 23:16, green in bits 15:8 and blue in bits 7:0. For a pixel whose luma is L, each channel takes the value {L, L[6]}. Red is 0 when L[6:4] is 6, blue is 0 when L[6:4] is 5, and green is never forced to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_start | input | 1 | One-cycle pulse that restarts decoding at the image base |
| rom_rd | output | 1 | ROM read enable |
| rom_addr | output | ADDR_W | ROM byte address |
| rom_data | input | 8 | ROM read data, valid one cycle after `rom_rd` |
| pix_ready | input | 1 | Downstream can accept a pixel |
| pix_valid | output | 1 | A pixel is presented |
| pix_luma | output | 7 | Pixel luma |
| pix_rgb | output | 24 | Palette colour of `pix_luma` |

## Verification
Most wrong internal states show up at the ports as soon as the next pixel is handed over. A bad count, a length group in the wrong slot or a missed continuation bit gives a run of the wrong length, and every pixel after it is then misaligned against the expected stream. A wrong head/length flag decodes a length byte as a pixel, or a pixel byte as a length, and so produces a wrong luma value within a few cycles. Faults in the address counter or the stall gating appear as a skipped byte on the very next read, or as a held pixel that changes while ready is low.

// File: rtl/rle_pkg.sv
package rle_pkg;

  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_BYTE  = 2'd1,
    ST_EMIT  = 2'd2
  } dec_state_t;

  localparam int GROUP_W = 7;

  function automatic logic byte_is_run(input logic [7:0] b);
    return b[0];
  endfunction

  function automatic logic [GROUP_W-1:0] byte_field(input logic [7:0] b);
    return b[7:1];
  endfunction

  // Place a 7-bit count group at slot idx (slot 0 is least significant).
  function automatic logic [31:0] place_group(input logic [GROUP_W-1:0] g,
                                              input int unsigned idx);
    return 32'(g) << (GROUP_W * idx);
  endfunction

  // Channel enable for palette: c=0 blue, c=1 green, c=2 red.
  function automatic logic chan_on(input logic [2:0] band, input int c);
    if (c == 2) return band != 3'd6;
    if (c == 0) return band != 3'd5;
    return 1'b1;
  endfunction

endpackage

// File: rtl/rle_fetch_addr.sv
module rle_fetch_addr #(
  parameter int ADDR_W   = 12,
  parameter int IMG_BASE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              want_byte,
  input  logic              pix_ready,
  output logic              rom_rd,
  output logic [ADDR_W-1:0] rom_addr
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(IMG_BASE);

  assign rom_rd = want_byte && pix_ready && !restart;

  always_ff @(posedge clk) begin
    if (!rst_n)       rom_addr <= BASE;
    else if (restart) rom_addr <= BASE;
    else if (rom_rd)  rom_addr <= rom_addr + ADDR_W'(1);
  end
endmodule

// File: rtl/rle_run_fsm.sv
module rle_run_fsm
  import rle_pkg::*;
#(
  parameter int LEN_BYTES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       rom_rd,
  input  logic [7:0] rom_data,
  input  logic       slot_free,
  output logic       want_byte,
  output logic       byte_evt,
  output logic       emit_evt,
  output logic [6:0] emit_luma
);
  localparam int COUNT_W = GROUP_W * LEN_BYTES;
  localparam int IDX_W   = (LEN_BYTES > 1) ? $clog2(LEN_BYTES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LEN_BYTES - 1);

  dec_state_t         st;
  logic               in_len;
  logic [IDX_W-1:0]   len_idx;
  logic [COUNT_W-1:0] count;
  logic [6:0]         luma;
  logic [COUNT_W-1:0] merged;
  logic               more_len;

  assign want_byte = (st == ST_FETCH);
  assign byte_evt  = (st == ST_BYTE);
  assign emit_evt  = (st == ST_EMIT) && slot_free && !restart;
  assign emit_luma = luma;

  always_comb begin
    merged   = count | COUNT_W'(place_group(byte_field(rom_data), 32'(len_idx)));
    more_len = rom_data[0] && (len_idx != LAST_IDX);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      st      <= ST_FETCH;
      in_len  <= 1'b0;
      len_idx <= '0;
      count   <= '0;
      luma    <= '0;
    end else begin
      unique case (st)
        ST_FETCH: if (rom_rd) st <= ST_BYTE;
        ST_BYTE: begin
          if (!in_len) begin
            luma <= byte_field(rom_data);
            if (byte_is_run(rom_data)) begin
              in_len  <= 1'b1;
              len_idx <= '0;
              count   <= '0;
              st      <= ST_FETCH;
            end else begin
              count <= COUNT_W'(1);
              st    <= ST_EMIT;
            end
          end else begin
            count <= merged;
            if (more_len) begin
              len_idx <= len_idx + IDX_W'(1);
              st      <= ST_FETCH;
            end else begin
              in_len <= 1'b0;
              st     <= (merged == '0) ? ST_FETCH : ST_EMIT;
            end
          end
        end
        ST_EMIT: if (emit_evt) begin
          count <= count - COUNT_W'(1);
          if (count == COUNT_W'(1)) st <= ST_FETCH;
        end
        default: st <= ST_FETCH;
      endcase
    end
  end
endmodule

// File: rtl/rle_pixel_out.sv
module rle_pixel_out
  import rle_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        restart,
  input  logic        emit_evt,
  input  logic [6:0]  emit_luma,
  input  logic        pix_ready,
  output logic        slot_free,
  output logic        pix_valid,
  output logic [6:0]  pix_luma,
  output logic [23:0] pix_rgb
);
  logic [7:0] chan;
  logic [2:0] band;

  assign slot_free = !pix_valid || pix_ready;
  assign chan      = {pix_luma, pix_luma[6]};
  assign band      = pix_luma[6:4];

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      pix_valid <= 1'b0;
      pix_luma  <= '0;
    end else if (emit_evt) begin
      pix_valid <= 1'b1;
      pix_luma  <= emit_luma;
    end else if (pix_ready) begin
      pix_valid <= 1'b0;
    end
  end

  for (genvar c = 0; c < 3; c++) begin : g_chan
    assign pix_rgb[c*8 +: 8] = chan_on(band, c) ? chan : 8'd0;
  end
endmodule

// File: rtl/rle_pixel_decoder.sv
module rle_pixel_decoder #(
  parameter int ADDR_W    = 12,
  parameter int IMG_BASE  = 16,
  parameter int LEN_BYTES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  output logic              rom_rd,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic [7:0]        rom_data,
  input  logic              pix_ready,
  output logic              pix_valid,
  output logic [6:0]        pix_luma,
  output logic [23:0]       pix_rgb
);
  logic       want_byte;
  logic       byte_evt;
  logic       emit_evt;
  logic [6:0] emit_luma;
  logic       slot_free;

  rle_fetch_addr #(.ADDR_W(ADDR_W), .IMG_BASE(IMG_BASE)) u_fetch (
    .clk(clk), .rst_n(rst_n), .restart(frame_start), .want_byte(want_byte),
    .pix_ready(pix_ready), .rom_rd(rom_rd), .rom_addr(rom_addr)
  );

  rle_run_fsm #(.LEN_BYTES(LEN_BYTES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .restart(frame_start), .rom_rd(rom_rd),
    .rom_data(rom_data), .slot_free(slot_free), .want_byte(want_byte),
    .byte_evt(byte_evt), .emit_evt(emit_evt), .emit_luma(emit_luma)
  );

  rle_pixel_out u_out (
    .clk(clk), .rst_n(rst_n), .restart(frame_start), .emit_evt(emit_evt),
    .emit_luma(emit_luma), .pix_ready(pix_ready), .slot_free(slot_free),
    .pix_valid(pix_valid), .pix_luma(pix_luma), .pix_rgb(pix_rgb)
  );
endmodule

// File: rtl/rle_decoder_checker.sv
module rle_decoder_checker #(
  parameter int ADDR_W   = 12,
  parameter int IMG_BASE = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic              rom_rd,
  input logic [ADDR_W-1:0] rom_addr,
  input logic              pix_ready,
  input logic              pix_valid,
  input logic [6:0]        pix_luma,
  input logic              byte_evt,
  input logic              emit_evt
);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && !pix_ready && !frame_start |=> pix_valid && $stable(pix_luma));

  a_r7_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_ready |-> !rom_rd);

  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (rom_addr == ADDR_W'(IMG_BASE)) && !pix_valid);

  a_r9_next_addr: assert property (@(posedge clk) disable iff (!rst_n)
    rom_rd && !frame_start |=> rom_addr == $past(rom_addr) + ADDR_W'(1));

  a_r9_byte_used: assert property (@(posedge clk) disable iff (!rst_n)
    rom_rd && !frame_start |=> byte_evt);

  a_r3_valid_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pix_valid) |-> $past(emit_evt));
endmodule

bind rle_pixel_decoder rle_decoder_checker #(.ADDR_W(ADDR_W), .IMG_BASE(IMG_BASE)) i_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .rom_rd(rom_rd),
  .rom_addr(rom_addr), .pix_ready(pix_ready), .pix_valid(pix_valid),
  .pix_luma(pix_luma), .byte_evt(byte_evt), .emit_evt(emit_evt)
);

// File: tb/test_rle_pixel_decoder.sv
module test_rle_pixel_decoder;
  localparam int ADDR_W   = 12;
  localparam int IMG_BASE = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              frame_start = 1'b0;
  logic              rom_rd;
  logic [ADDR_W-1:0] rom_addr;
  logic [7:0]        rom_data = 8'd0;
  logic              pix_ready = 1'b0;
  logic              pix_valid;
  logic [6:0]        pix_luma;
  logic [23:0]       pix_rgb;

  always #4 clk = ~clk;

  rle_pixel_decoder #(.ADDR_W(ADDR_W), .IMG_BASE(IMG_BASE)) i_rle_pixel_decoder (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .rom_rd(rom_rd),
    .rom_addr(rom_addr), .rom_data(rom_data), .pix_ready(pix_ready),
    .pix_valid(pix_valid), .pix_luma(pix_luma), .pix_rgb(pix_rgb)
  );

  logic [7:0] mem [0:(1<<ADDR_W)-1];
  always @(posedge clk) if (rom_rd) rom_data <= mem[rom_addr];

  int         checks = 0;
  int         failures = 0;
  string      cur_req = "R1";
  logic [6:0] expq[$];
  int         wptr = IMG_BASE;
  int         exp_addr = IMG_BASE;
  bit         ready_en = 0;
  bit         hold = 0;
  int         mode = 0;
  int         cyc = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] ref_rgb(input logic [6:0] l);
    logic [7:0] v;
    logic [7:0] r;
    logic [7:0] b;
    v = {l, l[6]};
    r = (l[6:4] == 3'd6) ? 8'd0 : v;
    b = (l[6:4] == 3'd5) ? 8'd0 : v;
    return {r, v, b};
  endfunction

  // Ready driver: runs after every input process at the edge.
  always begin
    bit pat;
    @(posedge clk);
    #2;
    cyc++;
    case (mode)
      0: pat = 1'b1;
      1: pat = (cyc % 3) != 0;
      default: pat = cyc[2];
    endcase
    pix_ready = ready_en && !hold && (expq.size() > 0) && pat;
  end

  // Monitor: scoreboard of handshakes and read addresses.
  always @(negedge clk) begin
    if (rst_n && pix_valid && pix_ready) begin
      if (expq.size() == 0) begin
        check(1'b0, cur_req, "unexpected pixel", int'(pix_luma), 0);
      end else begin
        logic [6:0] e;
        e = expq.pop_front();
        check(pix_luma == e, cur_req, "luma", int'(pix_luma), int'(e));
        check(pix_rgb == ref_rgb(pix_luma), "R10", "rgb", int'(pix_rgb),
              int'(ref_rgb(pix_luma)));
      end
    end
    if (rst_n && rom_rd) begin
      check(int'(rom_addr) == exp_addr, "R9", "read address", int'(rom_addr), exp_addr);
      exp_addr++;
    end
  end

  task automatic put(input logic [7:0] b);
    mem[wptr] = b;
    wptr++;
  endtask

  task automatic lit(input logic [6:0] v);
    put({v, 1'b0});
    expq.push_back(v);
  endtask

  task automatic run(input logic [6:0] v, input int n, input int nbytes,
                     input bit force_cont);
    put({v, 1'b1});
    for (int k = 0; k < nbytes; k++) begin
      logic [6:0] g;
      bit         c;
      g = 7'((n >> (7 * k)) & 127);
      c = (k < nbytes - 1) || force_cont;
      put({g, c});
    end
    for (int i = 0; i < n; i++) expq.push_back(v);
  endtask

  task automatic restart_frame();
    @(posedge clk);
    #1 frame_start = 1'b1;
    exp_addr = IMG_BASE;
    @(posedge clk);
    #1 frame_start = 1'b0;
    @(negedge clk);
    check(pix_valid == 1'b0, "R8", "valid after frame start", int'(pix_valid), 0);
    check(int'(rom_addr) == IMG_BASE, "R8", "address after frame start",
          int'(rom_addr), IMG_BASE);
  endtask

  task automatic new_image(input string req, input int m);
    ready_en = 0;
    hold = 0;
    restart_frame();
    expq.delete();
    wptr = IMG_BASE;
    cur_req = req;
    mode = m;
  endtask

  task automatic drain();
    ready_en = 1;
    while (expq.size() > 0) @(posedge clk);
    repeat (3) @(posedge clk);
    #1 ready_en = 0;
  endtask

  initial begin
    for (int i = 0; i < (1 << ADDR_W); i++) mem[i] = 8'd0;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired pending=%0d expected=0", expq.size());
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      check(pix_valid == 1'b0, "R1", "valid in reset", int'(pix_valid), 0);
      check(rom_rd == 1'b0, "R1", "read in reset", int'(rom_rd), 0);
      check(int'(rom_addr) == IMG_BASE, "R1", "address in reset", int'(rom_addr), IMG_BASE);
    end
    @(posedge clk);
    #1 rst_n = 1'b1;

    // R2: literal bytes
    new_image("R2", 0);
    lit(7'h00); lit(7'h7F); lit(7'h2A); lit(7'h55);
    drain();

    // R3: single length byte runs
    new_image("R3", 1);
    run(7'h7F, 5, 1, 0); run(7'h13, 127, 1, 0); lit(7'h01);
    drain();

    // R4: two and three length bytes
    new_image("R4", 1);
    run(7'h21, 260, 2, 0); run(7'h42, 16387, 3, 0); lit(7'h10);
    drain();

    // R5: zero counts produce nothing
    new_image("R5", 2);
    run(7'h44, 0, 1, 0); lit(7'h55); run(7'h66, 0, 2, 0); lit(7'h77);
    drain();

    // R6: continuation bit of third length byte ignored
    new_image("R6", 0);
    run(7'h11, 2, 3, 1); lit(7'h22);
    drain();

    // R10: palette across all bands
    new_image("R10", 2);
    for (int k = 0; k < 8; k++) lit(7'(k * 16 + 3));
    lit(7'h5F); lit(7'h6C);
    drain();

    // R7: stall holds output and fetches
    new_image("R7", 0);
    run(7'h3C, 30, 1, 0); lit(7'h01);
    ready_en = 1;
    while (expq.size() > 20) @(posedge clk);
    #1 hold = 1;
    @(negedge clk);
    begin
      logic [6:0] held;
      held = pix_luma;
      check(pix_valid == 1'b1, "R7", "valid at stall", int'(pix_valid), 1);
      repeat (8) begin
        @(negedge clk);
        check(pix_valid == 1'b1, "R7", "valid held", int'(pix_valid), 1);
        check(pix_luma == held, "R7", "luma held", int'(pix_luma), int'(held));
        check(rom_rd == 1'b0, "R7", "no read while stalled", int'(rom_rd), 0);
      end
    end
    hold = 0;
    drain();

    // R8: frame start mid-run restarts at the image base
    new_image("R8", 0);
    lit(7'h33); run(7'h05, 40, 1, 0);
    ready_en = 1;
    while (expq.size() > 25) @(posedge clk);
    #1 hold = 1;
    restart_frame();
    expq.delete();
    wptr = IMG_BASE;
    lit(7'h33); run(7'h05, 40, 1, 0);
    hold = 0;
    drain();

    check(expq.size() == 0, "R8", "pending pixels", expq.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule